// File: doc/BRIEF.md
# Eight-Function ALU with Flag Register

This block is an 8-bit arithmetic and logic unit. It takes two operand buses, a left and a right, and a 3-bit operation select. It puts the outcome on a result bus through logic with no clock. It also reports four status flags for that outcome: carry, signed overflow, zero and negative.

Addition, addition with stored carry, subtraction and compare all go through one adder. To subtract, the adder XOR-inverts the right operand and forces its carry-in high. Compare runs the same subtraction, but only for its flags: the result bus carries the left operand unchanged.

A small clocked flag register captures the four flags on a clock edge when its load enable is high. Its carry bit is the carry-in used by the add-with-carry operation.

Top module: `alu8_core`

## Requirements
- R1: Select codes 000, 001 and 011 give the bitwise AND, OR and XOR of the left and right operands on the result bus.
- R2: Select code 010 puts the bitwise inverse of the left operand on the result bus, and the right operand has no effect.
- R3: Select code 101 gives the low 8 bits of left plus right, with carry-in 0 whatever the stored carry; the carry flag is the carry out of bit 7.
- R4: Select code 110 gives left plus right plus the stored carry bit, with the carry flag as the carry out of bit 7.
- R5: Select code 111 gives left minus right modulo 256; the carry flag is the adder carry out, which is 1 exactly when left >= right taken as unsigned.
- R6: Select code 100 drives the left operand unchanged onto the result bus. Zero, negative, carry and overflow come from the internal left-minus-right difference, so zero is 1 exactly when the operands are equal.
- R7: For select codes 100 to 111 the overflow flag is 1 exactly when the signed two's-complement adder result does not fit in 8 bits.
- R8: For every code except 100, zero is 1 exactly when the result bus is all zeros, and negative equals bit 7 of the result bus.
- R9: Select codes 000 to 011 drive carry and overflow to 0.
- R10: The result bus and flags follow changes of the select and operands with no clock edge in between.
- R11: On a rising clock edge with the load enable high, the flag register captures the current flags as flag_reg_o = {negative, zero, overflow, carry} (bit 3 down to bit 0). With the load enable low it holds its value.
- R12: A synchronous reset, active high, clears the flag register to 0000 and takes priority over loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| opsel | input | 3 | Operation select |
| left_i | input | 8 | Left operand |
| right_i | input | 8 | Right operand |
| flag_load | input | 1 | Load enable for the flag register |
| result_o | output | 8 | Combinational result bus |
| carry_o | output | 1 | Carry out of bit 7 (0 for logic operations) |
| ovf_o | output | 1 | Signed overflow (0 for logic operations) |
| zero_o | output | 1 | Result (or compare difference) is zero |
| neg_o | output | 1 | Bit 7 of result (or compare difference) |
| flag_reg_o | output | 4 | Stored flags {neg, zero, ovf, carry} |

## Verification
The case hardest to reach from the ports is add-with-carry while the stored carry is 1. The bench gets there by first running an addition that carries out of bit 7 and loading its flags. Only then does it apply add-with-carry, and also plain add, to show that add ignores the stored bit. The compare tests pair equal and unequal operands whose difference has bit 7 set. This shows that zero and negative come from the hidden difference while the result bus still carries the left operand.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_NOT = 3'b010,
        OP_XOR = 3'b011,
        OP_CMP = 3'b100,
        OP_ADD = 3'b101,
        OP_ADC = 3'b110,
        OP_SUB = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_NOT:  y = ~a;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cin_stored,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           ovf
);

    localparam int SW = W + 1;

    logic           subtract;
    logic [W-1:0]   b_eff;
    logic           cin;
    logic [SW-1:0]  total;

    always_comb begin
        subtract = (op == OP_SUB) || (op == OP_CMP);
        // invert the right operand through XOR gating
        b_eff    = b ^ {W{subtract}};
        // carry-in: forced high for subtraction, stored bit for ADC only
        cin      = subtract | ((op == OP_ADC) & cin_stored);
        total    = {1'b0, a} + {1'b0, b_eff} + SW'(cin);
        sum      = total[W-1:0];
        cout     = total[W];
        ovf      = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  alu_flags_t  flags_in,
    output alu_flags_t  flags_q
);

    typedef struct packed {
        alu_flags_t flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.flags = flags_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flags_q = st_q.flags;

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   opsel,
    input  logic [W-1:0] left_i,
    input  logic [W-1:0] right_i,
    input  logic         flag_load,
    output logic [W-1:0] result_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         zero_o,
    output logic         neg_o,
    output logic [3:0]   flag_reg_o
);

    alu_op_e        op;
    logic [W-1:0]   logic_y;
    logic [W-1:0]   arith_sum;
    logic           arith_cout;
    logic           arith_ovf;
    logic [W-1:0]   flag_src;
    logic           is_arith;
    alu_flags_t     flags_now;
    alu_flags_t     flags_stored;

    assign op = alu_op_e'(opsel);

    alu8_logic #(.W(W)) u_logic (
        .op (op),
        .a  (left_i),
        .b  (right_i),
        .y  (logic_y)
    );

    alu8_arith #(.W(W)) u_arith (
        .op         (op),
        .a          (left_i),
        .b          (right_i),
        .cin_stored (flags_stored.carry),
        .sum        (arith_sum),
        .cout       (arith_cout),
        .ovf        (arith_ovf)
    );

    always_comb begin
        is_arith = opsel[2];
        if (op == OP_CMP)
            result_o = left_i;
        else if (is_arith)
            result_o = arith_sum;
        else
            result_o = logic_y;
        // compare judges zero/negative on the hidden difference
        flag_src        = (op == OP_CMP) ? arith_sum : result_o;
        flags_now.zero  = (flag_src == '0);
        flags_now.neg   = flag_src[W-1];
        flags_now.carry = is_arith & arith_cout;
        flags_now.ovf   = is_arith & arith_ovf;
    end

    assign carry_o = flags_now.carry;
    assign ovf_o   = flags_now.ovf;
    assign zero_o  = flags_now.zero;
    assign neg_o   = flags_now.neg;

    alu8_flagreg u_flags (
        .clk      (clk),
        .rst      (rst),
        .load     (flag_load),
        .flags_in (flags_now),
        .flags_q  (flags_stored)
    );

    assign flag_reg_o = flags_stored;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   opsel,
    input logic [W-1:0] left_i,
    input logic [W-1:0] result_o,
    input logic         carry_o,
    input logic         ovf_o,
    input logic         zero_o,
    input logic         neg_o,
    input logic         flag_load,
    input logic [3:0]   flag_reg_o
);

    // R9
    logic_clears_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (opsel[2] == 1'b0) |-> (!carry_o && !ovf_o));

    // R6
    cmp_passes_left_chk: assert property (@(posedge clk) disable iff (rst)
        (opsel == 3'b100) |-> (result_o == left_i));

    // R8
    zero_neg_track_chk: assert property (@(posedge clk) disable iff (rst)
        (opsel != 3'b100) |-> ((zero_o == (result_o == '0)) && (neg_o == result_o[W-1])));

    // R11
    flag_capture_chk: assert property (@(posedge clk) disable iff (rst)
        flag_load |=> (flag_reg_o == $past({neg_o, zero_o, ovf_o, carry_o})));

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_load |=> $stable(flag_reg_o));

    // R12
    flag_reset_chk: assert property (@(posedge clk)
        rst |=> (flag_reg_o == 4'b0000));

endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .opsel      (opsel),
    .left_i     (left_i),
    .result_o   (result_o),
    .carry_o    (carry_o),
    .ovf_o      (ovf_o),
    .zero_o     (zero_o),
    .neg_o      (neg_o),
    .flag_load  (flag_load),
    .flag_reg_o (flag_reg_o)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] opsel = 3'b000;
    logic [7:0] left_i = '0;
    logic [7:0] right_i = '0;
    logic       flag_load = 1'b0;
    logic [7:0] result_o;
    logic       carry_o, ovf_o, zero_o, neg_o;
    logic [3:0] flag_reg_o;

    int errors = 0;
    int checks = 0;
    logic [3:0] exp_store = 4'b0000;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu8_core uut (
        .clk(clk), .rst(rst), .opsel(opsel), .left_i(left_i), .right_i(right_i),
        .flag_load(flag_load), .result_o(result_o), .carry_o(carry_o),
        .ovf_o(ovf_o), .zero_o(zero_o), .neg_o(neg_o), .flag_reg_o(flag_reg_o)
    );

    // returns {result[7:0], neg, zero, ovf, carry}
    function automatic logic [11:0] model(input logic [2:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic cst);
        logic [7:0] r, d;
        logic [8:0] s;
        logic c, v;
        c = 1'b0; v = 1'b0; d = '0;
        case (op)
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: r = ~a;
            3'b011: r = a ^ b;
            3'b101: begin s = {1'b0,a} + {1'b0,b}; r = s[7:0]; c = s[8];
                    v = ($signed({a[7],a}) + $signed({b[7],b})) > 127 ||
                        ($signed({a[7],a}) + $signed({b[7],b})) < -128; end
            3'b110: begin s = {1'b0,a} + {1'b0,b} + {8'b0,cst}; r = s[7:0]; c = s[8];
                    v = ($signed({a[7],a}) + $signed({b[7],b}) + $signed({1'b0,cst})) > 127 ||
                        ($signed({a[7],a}) + $signed({b[7],b}) + $signed({1'b0,cst})) < -128; end
            default: begin // SUB and CMP
                    r = a - b; c = (a >= b);
                    v = ($signed({a[7],a}) - $signed({b[7],b})) > 127 ||
                        ($signed({a[7],a}) - $signed({b[7],b})) < -128; end
        endcase
        d = r;
        if (op == 3'b100) r = a;
        return {r, d[7], (d == 8'h00), v, c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [11:0] e;
        @(negedge clk);
        opsel = op; left_i = a; right_i = b;
        #1;
        e = model(op, a, b, exp_store[0]);
        check(req, {20'b0, result_o, neg_o, zero_o, ovf_o, carry_o}, {20'b0, e});
    endtask

    task automatic load_flags(input string req, input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
        logic [11:0] e;
        @(negedge clk);
        opsel = op; left_i = a; right_i = b; flag_load = 1'b1;
        e = model(op, a, b, exp_store[0]);
        @(negedge clk);
        flag_load = 1'b0;
        exp_store = e[3:0];
        check(req, {28'b0, flag_reg_o}, {28'b0, exp_store});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R12 reset state", {28'b0, flag_reg_o}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_logic;
        apply("R1 AND", 3'b000, 8'hF0, 8'h3C);
        apply("R1 OR",  3'b001, 8'hA0, 8'h05);
        apply("R1 XOR", 3'b011, 8'hFF, 8'h0F);
        apply("R8 AND zero", 3'b000, 8'hAA, 8'h55);
        apply("R9 logic clears carry", 3'b001, 8'hFF, 8'hFF);
    endtask

    task automatic t_not;
        apply("R2 NOT", 3'b010, 8'h5A, 8'h00);
        apply("R2 NOT right ignored", 3'b010, 8'h5A, 8'hFF);
        check("R2 NOT value", {24'b0, result_o}, 32'hA5);
    endtask

    task automatic t_add_carry;
        load_flags("R11 load carry from ADD", 3'b101, 8'hF0, 8'h20);
        check("R3 stored carry set", {31'b0, flag_reg_o[0]}, 32'h1);
        apply("R3 ADD ignores stored carry", 3'b101, 8'h10, 8'h01);
        check("R3 ADD value", {24'b0, result_o}, 32'h11);
        apply("R4 ADC with carry 1", 3'b110, 8'h10, 8'h01);
        check("R4 ADC value", {24'b0, result_o}, 32'h12);
        apply("R4 ADC wrap", 3'b110, 8'hFF, 8'h00);
        load_flags("R11 load cleared carry", 3'b101, 8'h01, 8'h01);
        apply("R4 ADC with carry 0", 3'b110, 8'h10, 8'h01);
    endtask

    task automatic t_sub_cmp;
        apply("R5 SUB no borrow", 3'b111, 8'h30, 8'h10);
        apply("R5 SUB borrow", 3'b111, 8'h10, 8'h30);
        apply("R5 SUB zero", 3'b111, 8'h42, 8'h42);
        apply("R6 CMP equal", 3'b100, 8'h77, 8'h77);
        check("R6 CMP equal zero", {31'b0, zero_o}, 32'h1);
        apply("R6 CMP negative diff", 3'b100, 8'h01, 8'h02);
        check("R6 CMP result is left", {24'b0, result_o}, 32'h01);
    endtask

    task automatic t_overflow;
        apply("R7 ADD pos overflow", 3'b101, 8'h7F, 8'h01);
        apply("R7 ADD neg overflow", 3'b101, 8'h80, 8'hFF);
        apply("R7 SUB overflow", 3'b111, 8'h80, 8'h01);
        apply("R7 SUB no overflow", 3'b111, 8'hFF, 8'h01);
    endtask

    task automatic t_comb;
        @(negedge clk);
        opsel = 3'b101; left_i = 8'h02; right_i = 8'h03;
        #1 check("R10 first", {24'b0, result_o}, 32'h05);
        left_i = 8'h20;
        #1 check("R10 follows without edge", {24'b0, result_o}, 32'h23);
    endtask

    task automatic t_hold_reset;
        load_flags("R11 load neg", 3'b111, 8'h00, 8'h01);
        @(negedge clk);
        opsel = 3'b000; left_i = 8'h01; right_i = 8'h01;
        @(negedge clk);
        check("R11 hold without load", {28'b0, flag_reg_o}, {28'b0, exp_store});
        rst = 1'b1; flag_load = 1'b1;
        @(negedge clk);
        rst = 1'b0; flag_load = 1'b0;
        exp_store = 4'b0000;
        check("R12 reset over load", {28'b0, flag_reg_o}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_not();
        t_add_carry();
        t_sub_cmp();
        t_overflow();
        t_comb();
        t_hold_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule